// File: doc/BRIEF.md
# SDRAM Command Decoder with Mode Register

This block sits at the command edge of a synchronous DRAM model. On every rising clock edge it samples the active-low chip-select, row-strobe, column-strobe and write-enable controls together with the address and bank inputs. It turns them into a one-hot set of registered command strobes: mode set, activate, read, write, precharge, refresh and no-op. It also captures the bank, row and column that go with each accepted command.

Address bit 8 of a read or write is passed on as an auto-precharge request. A mode-set command loads a mode register that holds the read latency, the burst length code and the burst ordering. A code the block cannot honour is refused: the register keeps its old contents and an error pulse is raised.

Decoding is gated in two ways. While clock enable is low, no strobe is produced at all. While chip select is high, only no-op is produced, so an operation already running elsewhere carries on undisturbed.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: Inputs are sampled only at the rising clock edge. Every output reflects the inputs sampled at the previous rising edge: one register stage, one cycle of latency.
- R2: With cke high and csN low, {rasN,casN,weN} decodes as follows: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 111 no-op. The unlisted code 110 also decodes as no-op.
- R3: At most one of the seven command strobes is high in any cycle.
- R4: With cke high and csN high, only cmdNop is asserted. The mode register and the captured addresses are unchanged.
- R5: With cke low, all seven strobes are low, whatever the other inputs are. The mode register and the captured addresses are unchanged.
- R6: An activate loads bankOut with the bank input and rowAddr with the full 12-bit address.
- R7: A read or write loads bankOut and colAddr (address bits 7:0). autoPre equals address bit 8 on a read or write strobe and is low in every other cycle.
- R8: A mode set takes its fields from the address. Bits 2:0 are the burst code: 1 = 2 beats, 2 = 4, 3 = 8, 7 = full page. Bit 3 is the ordering: 0 = sequential, 1 = interleaved. Bits 6:4 are the read latency. A legal word is loaded in the same cycle that cmdMrs is asserted.
- R9: A mode word is illegal if its latency is outside 3..5, its burst code is outside {1,2,3,7}, or it asks for full page with interleaved ordering. Such a word leaves the mode register unchanged and raises modeErr for exactly that cycle. modeErr is low in every other cycle.
- R10: After reset, all strobes and modeErr are low. readLatency is 3, burstCode is 1, interleave is 0, and bankOut, rowAddr, colAddr and autoPre are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low suppresses decoding |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | 12 | Multiplexed row / column / mode address |
| bank | input | 2 | Bank select |
| cmdMrs | output | 1 | Mode set strobe |
| cmdAct | output | 1 | Activate strobe |
| cmdRead | output | 1 | Read strobe |
| cmdWrite | output | 1 | Write strobe |
| cmdPre | output | 1 | Precharge strobe |
| cmdRef | output | 1 | Refresh strobe |
| cmdNop | output | 1 | No-op strobe |
| bankOut | output | 2 | Bank of the last accepted command |
| rowAddr | output | 12 | Row of the last activate |
| colAddr | output | 8 | Column of the last read or write |
| autoPre | output | 1 | Auto-precharge request with read or write |
| readLatency | output | 3 | Programmed read latency in clocks |
| burstCode | output | 3 | Programmed burst length code |
| interleave | output | 1 | Programmed burst ordering |
| modeErr | output | 1 | One-cycle pulse on a rejected mode word |

## Verification
The bench aims at the illegal mode words: latency 2 and 6, burst codes 0 and 4, and full page combined with interleaved ordering. A design that loaded any of these would report a latency or length the array cannot deliver. It also drives a mode-set code while the chip is deselected and while clock enable is low. A decoder that ignored either gate would rewrite the mode register or emit a stray strobe. Reads and writes are sent with address bit 8 both set and clear, to expose an auto-precharge flag that leaks into other commands or sticks from an earlier one. The 110 code must not raise a real command.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  typedef struct packed {
    logic mrs;
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic rfsh;
    logic nop;
  } cmdStrobe_t;

  localparam int LAT_MIN = 3;
  localparam int LAT_MAX = 5;
  localparam int MODE_BL_LSB = 0;
  localparam int MODE_BT_BIT = 3;
  localparam int MODE_LAT_LSB = 4;
  localparam logic [2:0] BL_FULL = 3'd7;
endpackage

// File: rtl/cmd_ctrl.sv
module cmd_ctrl
  import sdram_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cke,
  input  logic       csN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  output cmdStrobe_t cmdNext,
  output cmdStrobe_t cmdQ
);
  always_comb begin
    cmdNext = '0;
    if (cke) begin
      if (csN) begin
        cmdNext.nop = 1'b1;
      end else begin
        unique case ({rasN, casN, weN})
          3'b000:  cmdNext.mrs  = 1'b1;
          3'b001:  cmdNext.rfsh = 1'b1;
          3'b010:  cmdNext.pre  = 1'b1;
          3'b011:  cmdNext.act  = 1'b1;
          3'b100:  cmdNext.wr   = 1'b1;
          3'b101:  cmdNext.rd   = 1'b1;
          default: cmdNext.nop  = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdQ <= '0;
    else       cmdQ <= cmdNext;
  end
endmodule

// File: rtl/mode_datapath.sv
module mode_datapath
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        cmdNext,
  input  logic [ROW_W-1:0]  addr,
  input  logic [BANK_W-1:0] bank,
  output logic [BANK_W-1:0] bankQ,
  output logic [ROW_W-1:0]  rowQ,
  output logic [COL_W-1:0]  colQ,
  output logic              autoPreQ,
  output logic [2:0]        latQ,
  output logic [2:0]        burstQ,
  output logic              ilvQ,
  output logic              errQ
);
  logic [2:0] latIn, burstIn;
  logic       ilvIn, latOk, burstOk, modeOk;

  assign latIn   = addr[MODE_LAT_LSB +: 3];
  assign burstIn = addr[MODE_BL_LSB +: 3];
  assign ilvIn   = addr[MODE_BT_BIT];
  assign latOk   = (int'(latIn) >= LAT_MIN) && (int'(latIn) <= LAT_MAX);

  always_comb begin
    unique case (burstIn)
      3'd1, 3'd2, 3'd3: burstOk = 1'b1;
      BL_FULL:          burstOk = !ilvIn;
      default:          burstOk = 1'b0;
    endcase
  end

  assign modeOk = latOk && burstOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latQ   <= 3'(LAT_MIN);
      burstQ <= 3'd1;
      ilvQ   <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      errQ <= cmdNext.mrs && !modeOk;
      if (cmdNext.mrs && modeOk) begin
        latQ   <= latIn;
        burstQ <= burstIn;
        ilvQ   <= ilvIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ    <= '0;
      rowQ     <= '0;
      colQ     <= '0;
      autoPreQ <= 1'b0;
    end else begin
      autoPreQ <= (cmdNext.rd || cmdNext.wr) && addr[AP_BIT];
      if (cmdNext.act) begin
        bankQ <= bank;
        rowQ  <= addr;
      end
      if (cmdNext.rd || cmdNext.wr) begin
        bankQ <= bank;
        colQ  <= addr[COL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [ROW_W-1:0]  addr,
  input  logic [BANK_W-1:0] bank,
  output logic              cmdMrs,
  output logic              cmdAct,
  output logic              cmdRead,
  output logic              cmdWrite,
  output logic              cmdPre,
  output logic              cmdRef,
  output logic              cmdNop,
  output logic [BANK_W-1:0] bankOut,
  output logic [ROW_W-1:0]  rowAddr,
  output logic [COL_W-1:0]  colAddr,
  output logic              autoPre,
  output logic [2:0]        readLatency,
  output logic [2:0]        burstCode,
  output logic              interleave,
  output logic              modeErr
);
  cmdStrobe_t cmdNext, cmdQ;

  cmd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN),
    .cmdNext(cmdNext), .cmdQ(cmdQ)
  );

  mode_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cmdNext(cmdNext), .addr(addr), .bank(bank),
    .bankQ(bankOut), .rowQ(rowAddr), .colQ(colAddr), .autoPreQ(autoPre),
    .latQ(readLatency), .burstQ(burstCode), .ilvQ(interleave), .errQ(modeErr)
  );

  assign cmdMrs   = cmdQ.mrs;
  assign cmdAct   = cmdQ.act;
  assign cmdRead  = cmdQ.rd;
  assign cmdWrite = cmdQ.wr;
  assign cmdPre   = cmdQ.pre;
  assign cmdRef   = cmdQ.rfsh;
  assign cmdNop   = cmdQ.nop;
endmodule

// File: rtl/sdram_cmd_decoder_chk.sv
module sdram_cmd_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cke,
  input logic       csN,
  input logic       cmdMrs,
  input logic       cmdAct,
  input logic       cmdRead,
  input logic       cmdWrite,
  input logic       cmdPre,
  input logic       cmdRef,
  input logic       cmdNop,
  input logic       autoPre,
  input logic [2:0] readLatency,
  input logic [2:0] burstCode,
  input logic       interleave,
  input logic       modeErr
);
  logic [6:0] strobes;
  assign strobes = {cmdMrs, cmdAct, cmdRead, cmdWrite, cmdPre, cmdRef, cmdNop};

  // R3
  onehot_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R5
  cke_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cke |=> (strobes == 7'd0));

  // R4
  deselect_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cke && csN) |=> cmdNop);

  // R7
  autopre_scope_chk: assert property (@(posedge clk) disable iff (!rstN)
    autoPre |-> (cmdRead || cmdWrite));

  // R9
  reject_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> ($stable(readLatency) && $stable(burstCode) && $stable(interleave)));

  // R9
  err_with_mrs_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> cmdMrs);

  // R8
  lat_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readLatency >= 3'd3) && (readLatency <= 3'd5));
endmodule

bind sdram_cmd_decoder sdram_cmd_decoder_chk chk_i (
  .clk(clk), .rstN(rstN), .cke(cke), .csN(csN),
  .cmdMrs(cmdMrs), .cmdAct(cmdAct), .cmdRead(cmdRead), .cmdWrite(cmdWrite),
  .cmdPre(cmdPre), .cmdRef(cmdRef), .cmdNop(cmdNop), .autoPre(autoPre),
  .readLatency(readLatency), .burstCode(burstCode), .interleave(interleave),
  .modeErr(modeErr)
);

// File: tb/sdram_cmd_decoder_tb.sv
module sdram_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b0, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [11:0] addr = '0;
  logic [1:0]  bank = '0;
  logic cmdMrs, cmdAct, cmdRead, cmdWrite, cmdPre, cmdRef, cmdNop;
  logic [1:0]  bankOut;
  logic [11:0] rowAddr;
  logic [7:0]  colAddr;
  logic autoPre, interleave, modeErr;
  logic [2:0] readLatency, burstCode;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // model state
  logic [6:0]  eCmd;
  logic [1:0]  eBank;
  logic [11:0] eRow;
  logic [7:0]  eCol;
  logic        eAp, eIlv, eErr;
  logic [2:0]  eLat, eBurst;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_decoder dut_i (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .addr(addr), .bank(bank),
    .cmdMrs(cmdMrs), .cmdAct(cmdAct), .cmdRead(cmdRead), .cmdWrite(cmdWrite),
    .cmdPre(cmdPre), .cmdRef(cmdRef), .cmdNop(cmdNop),
    .bankOut(bankOut), .rowAddr(rowAddr), .colAddr(colAddr), .autoPre(autoPre),
    .readLatency(readLatency), .burstCode(burstCode), .interleave(interleave),
    .modeErr(modeErr)
  );

  // bit order: {mrs,act,rd,wr,pre,ref,nop}
  function automatic logic [6:0] expCmd(logic k, logic c, logic r, logic a, logic w);
    if (!k) return 7'b0000000;
    if (c) return 7'b0000001;
    case ({r, a, w})
      3'b000: return 7'b1000000;
      3'b001: return 7'b0000010;
      3'b010: return 7'b0000100;
      3'b011: return 7'b0100000;
      3'b100: return 7'b0001000;
      3'b101: return 7'b0010000;
      default: return 7'b0000001;
    endcase
  endfunction

  function automatic bit modeLegal(logic [11:0] a);
    logic [2:0] lat, bl;
    lat = a[6:4];
    bl = a[2:0];
    if (lat < 3 || lat > 5) return 0;
    if (bl == 3'd7) return !a[3];
    return (bl >= 3'd1 && bl <= 3'd3);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, model after posedge, compare at next negedge
  task automatic step(logic k, logic c, logic r, logic a, logic w,
                      logic [11:0] ad, logic [1:0] bk);
    logic [6:0] ec;
    cke = k; csN = c; rasN = r; casN = a; weN = w; addr = ad; bank = bk;
    @(posedge clk);
    ec = expCmd(k, c, r, a, w);
    eCmd = ec;
    eErr = 0;
    eAp = (ec[4] || ec[3]) && ad[8];
    if (ec[5]) begin eBank = bk; eRow = ad; end
    if (ec[4] || ec[3]) begin eBank = bk; eCol = ad[7:0]; end
    if (ec[6]) begin
      if (modeLegal(ad)) begin
        eLat = ad[6:4]; eBurst = ad[2:0]; eIlv = ad[3];
      end else eErr = 1;
    end
    @(negedge clk);
    check(!k ? "R5" : (c ? "R4" : "R2"), "strobes",
          {cmdMrs, cmdAct, cmdRead, cmdWrite, cmdPre, cmdRef, cmdNop}, eCmd);
    check("R6", "bank", bankOut, eBank);
    check("R6", "row", rowAddr, eRow);
    check("R7", "col", colAddr, eCol);
    check("R7", "autoPre", autoPre, eAp);
    check("R8", "latency", readLatency, eLat);
    check("R8", "burst", burstCode, eBurst);
    check("R8", "interleave", interleave, eIlv);
    check("R9", "modeErr", modeErr, eErr);
  endtask

  task automatic mrs(logic [11:0] ad);
    step(1, 0, 0, 0, 0, ad, 2'd0);
  endtask

  initial begin
    eCmd = 0; eBank = 0; eRow = 0; eCol = 0; eAp = 0; eIlv = 0; eErr = 0;
    eLat = 3'd3; eBurst = 3'd1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "strobes", {cmdMrs, cmdAct, cmdRead, cmdWrite, cmdPre, cmdRef, cmdNop}, 0);
    check("R10", "latency", readLatency, 3);
    check("R10", "burst", burstCode, 1);
    check("R10", "interleave", interleave, 0);
    check("R10", "modeErr", modeErr, 0);
    check("R10", "autoPre", autoPre, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R8 legal words
    mrs(12'h052);             // lat 5, burst 4 beats, sequential
    mrs(12'h04B);             // lat 4, 8 beats, interleaved
    mrs(12'h037);             // lat 3, full page, sequential
    // R9 illegal words
    mrs(12'h021);             // latency 2
    mrs(12'h061);             // latency 6
    mrs(12'h040);             // burst code 0
    mrs(12'h044);             // burst code 4
    mrs(12'h03F);             // full page interleaved
    // R4 deselected mode code; R5 clock disabled mode code
    step(1, 1, 0, 0, 0, 12'h052, 2'd0);
    step(0, 0, 0, 0, 0, 12'h052, 2'd0);
    step(0, 0, 0, 1, 1, 12'hABC, 2'd3);
    // R6 activate, R7 read/write with and without auto precharge
    step(1, 0, 0, 1, 1, 12'hA5C, 2'd2);
    step(1, 0, 1, 0, 1, 12'h1F3, 2'd1);
    step(1, 0, 1, 0, 1, 12'h0F3, 2'd3);
    step(1, 0, 1, 0, 0, 12'h17E, 2'd0);
    step(1, 0, 1, 1, 1, 12'h100, 2'd2);  // no-op with bit 8 set
    step(1, 0, 1, 1, 0, 12'h1FF, 2'd1);  // 110 code is no-op (R2)

    // random phase (R1, R3 and all of the above)
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 600; i++) begin
      logic [11:0] ad;
      logic k, c;
      k = ($urandom % 8) != 0;
      c = ($urandom % 6) == 0;
      ad = 12'($urandom);
      if (($urandom % 2) == 0) ad[6:4] = 3'(3 + $urandom % 3);
      step(k, c, 1'($urandom), 1'($urandom), 1'($urandom), ad, 2'($urandom));
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule